// File: doc/BRIEF.md
# Oversampled Asynchronous Serial Transceiver

This block is a single asynchronous character channel. It has one transmitter and one receiver. Both run from the same clock, and that clock is the bit clock. A two-bit clock-mode input sets how many clocks make up one bit time: 1, 16, 32 or 64. A configuration input also sets:
- the character length, 5 to 8 bits;
- the stop-bit setting: one, one and a half, two, or "not asynchronous";
- whether a parity bit is used, and whether that parity is even or odd.

The transmitter takes a parallel character through a ready/valid handshake. It sends a low start bit, then the data bits least significant first, then the optional parity bit, then the stop time. The line rests high between characters.

The receiver watches the serial input for a falling edge. In the oversampled modes it checks the start bit again at its middle, then samples each later bit at its centre. It returns the character right-aligned with a one-cycle valid strobe. A parity-error flag and a framing-error flag travel with each character. The data and both flags stay unchanged until the next character arrives.

Configuration is expected to change only while both directions are idle. One combination is not allowed: one and a half stop bits with the 1X clock mode. The block reports this combination and refuses to transmit while it is set.

Top module: `async_serial_port`

## Requirements
- R1: Clock-mode code 00/01/10/11 makes each transmitted bit last 1/16/32/64 clocks, and the receiver uses the same bit period.
- R2: Character-length code 00 selects 5 data bits, 01 selects 7, 10 selects 6 and 11 selects 8, in both directions. Data bits travel least significant first after a single low start bit.
- R3: With parity enabled, one parity bit follows the last data bit. When the sense input is 1 the parity is even (data plus parity has an even count of ones); when it is 0 the parity is odd. With parity disabled, the sense input has no effect on the line.
- R4: The line idles high. The stop time is high for 1, 1.5 or 2 bit times for stop codes 01, 10 and 11. `tx_ready` stays low from acceptance until the whole stop time has passed, and a character is accepted only when `tx_valid` and `tx_ready` are both high at a clock edge.
- R5: Stop code 00 turns asynchronous operation off. `tx_ready` is low, `sout` stays high, and no character is received.
- R6: Stop code 10 together with clock mode 00 raises `cfg_bad`. While it is raised, `tx_ready` is low and `sout` stays high. `cfg_bad` is low for every other combination.
- R7: The receiver starts on a falling edge of `sin`. In the oversampled modes, a low that has gone again by mid-bit is discarded, and the receiver returns to idle.
- R8: Received data is right-aligned in `rx_data`, with zeros above it. With parity enabled and a length below 8, the received parity bit appears at bit position equal to the length. With length 8 the parity bit is not returned.
- R9: `rx_par_err` is set when the received parity bit does not match the programmed sense, and clear otherwise or when parity is disabled.
- R10: The receiver checks exactly one stop bit, whatever the stop setting. `rx_frm_err` is set when that bit is sampled low. A new start bit directly after one stop bit is received correctly, even with stop code 11.
- R11: `rx_valid` is a single-cycle pulse per character. `rx_data`, `rx_par_err` and `rx_frm_err` change only when it is pulsed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_clk_mode | input | 2 | Clocks per bit: 00=1, 01=16, 10=32, 11=64 |
| cfg_len | input | 2 | Character length: 00=5, 01=7, 10=6, 11=8 |
| cfg_stop | input | 2 | 00=async off, 01=1, 10=1.5, 11=2 stop bits |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_even | input | 1 | 1 = even parity, 0 = odd |
| tx_data | input | 8 | Character to send (unused upper bits ignored) |
| tx_valid | input | 1 | Transmit request |
| tx_ready | output | 1 | Transmitter can accept a character |
| rx_data | output | 8 | Last received character |
| rx_valid | output | 1 | One-cycle strobe for a new character |
| rx_par_err | output | 1 | Parity mismatch on the last character |
| rx_frm_err | output | 1 | Stop bit of the last character was low |
| sin | input | 1 | Serial input line |
| sout | output | 1 | Serial output line |
| cfg_bad | output | 1 | Forbidden 1.5-stop / 1X combination selected |

## Verification
The transmit line falls on the same clock edge that accepts a character. Each later bit begins exactly N clocks after the one before it, and `tx_ready` returns exactly frame-length-plus-stop-time clocks after acceptance. The bench counts falling edges from the acceptance edge and compares `sout` and `tx_ready` on every one of them.

A received result is due about half a bit plus two register stages into the stop bit. The bench does not check that cycle exactly. Instead, a monitor latches every strobe. The checks read that monitor only after the stop bit, one idle bit and two further clocks have passed, so they always follow the strobe they expect.

// File: rtl/async_serial_port.sv
module async_serial_port #(
  parameter int CNT_W = 7
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] cfg_clk_mode,
  input  logic [1:0] cfg_len,
  input  logic [1:0] cfg_stop,
  input  logic       cfg_par_en,
  input  logic       cfg_par_even,
  input  logic [7:0] tx_data,
  input  logic       tx_valid,
  output logic       tx_ready,
  output logic [7:0] rx_data,
  output logic       rx_valid,
  output logic       rx_par_err,
  output logic       rx_frm_err,
  input  logic       sin,
  output logic       sout,
  output logic       cfg_bad
);
  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP} st_t;

  logic [CNT_W-1:0] bit_m1, half_m1, stop_m1;
  logic [3:0] nbits;
  logic [7:0] mask;
  logic active;

  always_comb begin
    case (cfg_clk_mode)
      2'b01:   begin bit_m1 = CNT_W'(15); half_m1 = CNT_W'(7);  end
      2'b10:   begin bit_m1 = CNT_W'(31); half_m1 = CNT_W'(15); end
      2'b11:   begin bit_m1 = CNT_W'(63); half_m1 = CNT_W'(31); end
      default: begin bit_m1 = '0;         half_m1 = '0;         end
    endcase
    case (cfg_stop)
      2'b10:   stop_m1 = bit_m1 + half_m1 + CNT_W'(1);
      2'b11:   stop_m1 = (bit_m1 << 1) + CNT_W'(1);
      default: stop_m1 = bit_m1;
    endcase
    case (cfg_len)
      2'b00:   nbits = 4'd5;
      2'b01:   nbits = 4'd7;
      2'b10:   nbits = 4'd6;
      default: nbits = 4'd8;
    endcase
  end

  assign mask    = 8'hFF >> (4'd8 - nbits);
  assign cfg_bad = (cfg_stop == 2'b10) && (cfg_clk_mode == 2'b00);
  assign active  = (cfg_stop != 2'b00) && !cfg_bad;

  // transmitter
  st_t tx_st;
  logic [CNT_W-1:0] tx_cnt;
  logic [2:0] tx_idx;
  logic [7:0] tx_sh;
  logic tx_par;
  logic [7:0] tx_masked;

  assign tx_masked = tx_data & mask;
  assign tx_ready  = (tx_st == S_IDLE) && active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_st  <= S_IDLE;
      tx_cnt <= '0;
      tx_idx <= '0;
      tx_sh  <= '0;
      tx_par <= 1'b0;
      sout   <= 1'b1;
    end else if (tx_st == S_IDLE) begin
      sout <= 1'b1;
      if (tx_valid && tx_ready) begin
        tx_sh  <= tx_masked;
        tx_par <= cfg_par_even ? ^tx_masked : ~^tx_masked;
        sout   <= 1'b0;
        tx_cnt <= bit_m1;
        tx_st  <= S_START;
      end
    end else if (tx_cnt != '0) begin
      tx_cnt <= tx_cnt - CNT_W'(1);
    end else begin
      case (tx_st)
        S_START: begin
          sout   <= tx_sh[0];
          tx_sh  <= tx_sh >> 1;
          tx_idx <= '0;
          tx_cnt <= bit_m1;
          tx_st  <= S_DATA;
        end
        S_DATA: begin
          if ({1'b0, tx_idx} == nbits - 4'd1) begin
            if (cfg_par_en) begin
              sout   <= tx_par;
              tx_cnt <= bit_m1;
              tx_st  <= S_PAR;
            end else begin
              sout   <= 1'b1;
              tx_cnt <= stop_m1;
              tx_st  <= S_STOP;
            end
          end else begin
            sout   <= tx_sh[0];
            tx_sh  <= tx_sh >> 1;
            tx_idx <= tx_idx + 3'd1;
            tx_cnt <= bit_m1;
          end
        end
        S_PAR: begin
          sout   <= 1'b1;
          tx_cnt <= stop_m1;
          tx_st  <= S_STOP;
        end
        default: tx_st <= S_IDLE;
      endcase
    end
  end

  // receiver
  st_t rx_st;
  logic [CNT_W-1:0] rx_cnt;
  logic [2:0] rx_idx;
  logic [7:0] rx_sh;
  logic rx_pbit, s1, s2;
  logic [7:0] rx_word;
  logic rx_par_exp;

  assign rx_par_exp = cfg_par_even ? ^rx_sh : ~^rx_sh;
  assign rx_word = rx_sh | ((cfg_par_en && nbits != 4'd8) ?
                            (8'({7'd0, rx_pbit}) << nbits) : 8'd0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b1;
      s2 <= 1'b1;
    end else begin
      s1 <= sin;
      s2 <= s1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_st      <= S_IDLE;
      rx_cnt     <= '0;
      rx_idx     <= '0;
      rx_sh      <= '0;
      rx_pbit    <= 1'b0;
      rx_data    <= '0;
      rx_valid   <= 1'b0;
      rx_par_err <= 1'b0;
      rx_frm_err <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      if (rx_st == S_IDLE) begin
        if (active && s2 && !s1) begin
          rx_sh  <= '0;
          rx_idx <= '0;
          if (cfg_clk_mode == 2'b00) begin
            rx_cnt <= '0;
            rx_st  <= S_DATA;
          end else begin
            rx_cnt <= half_m1;
            rx_st  <= S_START;
          end
        end
      end else if (rx_cnt != '0) begin
        rx_cnt <= rx_cnt - CNT_W'(1);
      end else begin
        case (rx_st)
          S_START: begin
            rx_cnt <= bit_m1;
            rx_st  <= s1 ? S_IDLE : S_DATA;
          end
          S_DATA: begin
            rx_sh[rx_idx] <= s1;
            rx_cnt        <= bit_m1;
            if ({1'b0, rx_idx} == nbits - 4'd1)
              rx_st <= cfg_par_en ? S_PAR : S_STOP;
            else
              rx_idx <= rx_idx + 3'd1;
          end
          S_PAR: begin
            rx_pbit <= s1;
            rx_cnt  <= bit_m1;
            rx_st   <= S_STOP;
          end
          default: begin
            rx_data    <= rx_word;
            rx_par_err <= cfg_par_en && (rx_pbit != rx_par_exp);
            rx_frm_err <= !s1;
            rx_valid   <= 1'b1;
            rx_st      <= S_IDLE;
          end
        endcase
      end
    end
  end
endmodule

module async_serial_port_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] cfg_clk_mode,
  input logic [1:0] cfg_stop,
  input logic       tx_valid,
  input logic       tx_ready,
  input logic       sout,
  input logic       rx_valid,
  input logic [7:0] rx_data,
  input logic       rx_par_err,
  input logic       rx_frm_err
);
  p_idle_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |-> sout);
  p_start_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> !sout);
  p_sync_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_stop == 2'b00) |-> !tx_ready);
  p_no_accept_bad_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_stop == 2'b10 && cfg_clk_mode == 2'b00) |-> !tx_ready);
  p_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);
  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_valid |-> ($stable(rx_data) && $stable(rx_par_err) && $stable(rx_frm_err)));
endmodule

bind async_serial_port async_serial_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_clk_mode(cfg_clk_mode), .cfg_stop(cfg_stop),
  .tx_valid(tx_valid), .tx_ready(tx_ready), .sout(sout),
  .rx_valid(rx_valid), .rx_data(rx_data), .rx_par_err(rx_par_err),
  .rx_frm_err(rx_frm_err)
);

// File: tb/tb_async_serial_port.sv
module tb_async_serial_port;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] mode = 2'b01, clen = 2'b11, stp = 2'b01;
  logic pe = 1'b0, pev = 1'b0;
  logic [7:0] tx_data = '0;
  logic tx_valid = 1'b0, sin_drv = 1'b1;
  logic tx_ready, rx_valid, rx_par_err, rx_frm_err, sout, cfg_bad;
  logic [7:0] rx_data;

  int total = 0, bad = 0, got_cnt = 0;
  logic [7:0] got_data = '0, prev_data = '0;
  logic got_pe = 1'b0, got_fe = 1'b0;

  always #10 clk = ~clk;

  async_serial_port dut (
    .clk(clk), .rst_n(rst_n), .cfg_clk_mode(mode), .cfg_len(clen), .cfg_stop(stp),
    .cfg_par_en(pe), .cfg_par_even(pev), .tx_data(tx_data), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .rx_data(rx_data), .rx_valid(rx_valid),
    .rx_par_err(rx_par_err), .rx_frm_err(rx_frm_err), .sin(sin_drv), .sout(sout),
    .cfg_bad(cfg_bad));

  always @(negedge clk) if (rx_valid) begin
    got_cnt++;
    prev_data = got_data;
    got_data = rx_data;
    got_pe = rx_par_err;
    got_fe = rx_frm_err;
  end

  function automatic int ratio();
    return mode == 2'b00 ? 1 : mode == 2'b01 ? 16 : mode == 2'b10 ? 32 : 64;
  endfunction
  function automatic int nb();
    return clen == 2'b00 ? 5 : clen == 2'b01 ? 7 : clen == 2'b10 ? 6 : 8;
  endfunction
  function automatic logic [7:0] msk();
    return 8'hFF >> (8 - nb());
  endfunction
  function automatic logic parbit(input logic [7:0] d);
    return pev ? ^(d & msk()) : ~^(d & msk());
  endfunction
  function automatic logic [7:0] rx_exp(input logic [7:0] d, input bit flip);
    logic [7:0] r = d & msk();
    if (pe && nb() < 8) r[nb()] = parbit(d) ^ flip;
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tx_frame(input logic [7:0] d);
    int n = ratio();
    int l = nb();
    int fr = (1 + l + int'(pe)) * n;
    int s = stp == 2'b01 ? n : stp == 2'b10 ? n + n / 2 : 2 * n;
    int errs = 0, rdy_bad = 0;
    @(negedge clk);
    tx_data = d;
    tx_valid = 1'b1;
    while (!tx_ready) @(negedge clk);
    @(negedge clk);
    tx_valid = 1'b0;
    for (int t = 0; t < fr + s; t++) begin
      int b = t / n;
      logic e;
      if (b == 0) e = 1'b0;
      else if (b <= l) e = d[b-1];
      else if (b == l + 1 && pe) e = parbit(d);
      else e = 1'b1;
      if (sout !== e) errs++;
      if (tx_ready) rdy_bad++;
      @(negedge clk);
    end
    check(errs == 0, "R1 R2 R3 tx bit timing/values", errs, 0);
    check(rdy_bad == 0 && tx_ready, "R4 stop time before ready", rdy_bad, 0);
  endtask

  task automatic rx_frame(input logic [7:0] d, input bit badpar, input bit badstop,
                          input int idle_bits, input bit do_check);
    int n = ratio();
    int base = got_cnt;
    sin_drv = 1'b0;
    repeat (n) @(negedge clk);
    for (int i = 0; i < nb(); i++) begin
      sin_drv = d[i];
      repeat (n) @(negedge clk);
    end
    if (pe) begin
      sin_drv = parbit(d) ^ badpar;
      repeat (n) @(negedge clk);
    end
    sin_drv = !badstop;
    repeat (n) @(negedge clk);
    sin_drv = 1'b1;
    repeat (idle_bits * n) @(negedge clk);
    if (do_check) begin
      repeat (2) @(negedge clk);
      check(got_cnt == base + 1, "R11 one strobe per character", got_cnt - base, 1);
      check(got_data == rx_exp(d, badpar), "R2 R8 rx data", got_data, rx_exp(d, badpar));
      check(got_pe == (pe && badpar), "R9 parity flag", got_pe, pe && badpar);
      check(got_fe == badstop, "R10 framing flag", got_fe, badstop);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=hang expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int base;
    void'($urandom(32'h5eed));
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(sout == 1'b1, "R4 idle high after reset", sout, 1);
    check(rx_valid == 1'b0 && got_cnt == 0, "R11 no strobe at reset", rx_valid, 0);
    check(tx_ready == 1'b1 && cfg_bad == 1'b0, "R4 ready after reset", tx_ready, 1);

    // R6 forbidden combination
    mode = 2'b00; stp = 2'b10;
    @(negedge clk);
    check(cfg_bad == 1'b1, "R6 cfg_bad raised", cfg_bad, 1);
    tx_valid = 1'b1; tx_data = 8'h00;
    base = 0;
    repeat (20) begin @(negedge clk); if (sout !== 1'b1 || tx_ready) base++; end
    tx_valid = 1'b0;
    check(base == 0, "R6 transmitter refuses", base, 0);
    stp = 2'b11;
    @(negedge clk);
    check(cfg_bad == 1'b0, "R6 cfg_bad clear otherwise", cfg_bad, 0);

    // R5 async off
    mode = 2'b01; stp = 2'b00;
    @(negedge clk);
    check(tx_ready == 1'b0, "R5 no ready when async off", tx_ready, 0);
    tx_valid = 1'b1;
    base = got_cnt;
    rx_frame(8'hA5, 0, 0, 2, 0);
    tx_valid = 1'b0;
    check(got_cnt == base && sout == 1'b1, "R5 nothing received or sent", got_cnt - base, 0);

    // R4 1.5 stop bits at 16X, R1 64X frame
    stp = 2'b10; clen = 2'b11; pe = 1'b0;
    tx_frame(8'h96);
    mode = 2'b11; stp = 2'b01; clen = 2'b00;
    tx_frame(8'h13);
    rx_frame(8'h1B, 0, 0, 1, 1);

    // R3 parity sense directed, sense ignored without parity
    mode = 2'b00; stp = 2'b11; clen = 2'b01; pe = 1'b1; pev = 1'b1;
    tx_frame(8'h55);
    pev = 1'b0;
    tx_frame(8'h55);
    pe = 1'b0; pev = 1'b1;
    tx_frame(8'h3C);
    // R8 parity bit returned at position 7 for 7-bit characters
    pe = 1'b1; pev = 1'b1; mode = 2'b01;
    rx_frame(8'h55, 0, 0, 1, 1);
    check(got_data == 8'h55, "R8 parity at bit 7", got_data, 8'h55);
    // R9 odd parity mismatch
    pev = 1'b0;
    rx_frame(8'h21, 1, 0, 1, 1);
    // R8 length 8 drops parity bit
    clen = 2'b11;
    rx_frame(8'hC3, 0, 0, 1, 1);

    // R10 back-to-back with single stop bit under stop code 11
    pe = 1'b0; clen = 2'b10; stp = 2'b11;
    base = got_cnt;
    rx_frame(8'h2A, 0, 0, 0, 0);
    rx_frame(8'h15, 0, 1, 1, 1);
    check(got_cnt == base + 2 && prev_data == 8'h2A, "R10 back-to-back first char",
          prev_data, 8'h2A);

    // R7 glitch rejection at 16X
    base = got_cnt;
    sin_drv = 1'b0;
    repeat (3) @(negedge clk);
    sin_drv = 1'b1;
    repeat (40) @(negedge clk);
    check(got_cnt == base, "R7 short low ignored", got_cnt - base, 0);
    rx_frame(8'h33, 0, 0, 1, 1);

    // constrained random
    for (int it = 0; it < 30; it++) begin
      logic [7:0] d = 8'($urandom);
      mode = 2'($urandom);
      clen = 2'($urandom);
      stp = 2'($urandom_range(3, 1));
      if (mode == 2'b00 && stp == 2'b10) stp = 2'b11;
      pe = 1'($urandom);
      pev = 1'($urandom);
      @(negedge clk);
      tx_frame(d);
      rx_frame(~d, ($urandom % 4) == 0, ($urandom % 4) == 0, 1, 1);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule